// File: doc/BRIEF.md
# Double-Buffered Compare Bank with Automatic Update Lock

This block keeps a small bank of compare values for a timer. Each channel has an active compare register, which the timer uses, and a shadow buffer that software writes. A per-channel pending flag shows that the buffer holds a value not yet copied. Copies from buffer to active register happen only on a timer UPDATE pulse, and only while the update-lock bit is clear. Timer counting and waveform output are handled elsewhere.

The lock bit can be driven by software alone, or by hardware in automatic mode. In automatic mode the lock is raised when the mode is switched on. It is released only after every enabled channel has a pending buffer. The next UPDATE then moves all pending values at once and raises the lock again. All enabled compare values therefore change in the same clock cycle, even when software writes them several cycles apart.

Top module: `cmp_shadow_bank`

## Requirements
- R1: After reset every active compare value is 0, every pending flag is 0, the lock bit is 0 and automatic mode is off.
- R2: A buffer write strobe sets that channel's pending flag on the next clock edge. A write by itself never changes any active compare value.
- R3: An UPDATE pulse while the lock bit is 0 copies each pending channel's buffer into its active register and clears its pending flag. Channels with no pending value keep their active value.
- R4: While the lock bit is 1, an UPDATE pulse changes no active value, and the pending flags stay as they were.
- R5: Writing 1 to the automatic-mode enable sets the lock bit on the next clock edge, whatever its previous value.
- R6: In automatic mode, a set lock bit clears on the clock edge after every enabled channel's pending flag is 1. Channels whose enable bit is 0 are left out of this check.
- R7: In automatic mode with no channel enabled, the lock bit clears on the clock edge after it was set.
- R8: In automatic mode, an UPDATE that copies buffers also sets the lock bit again. All enabled compare values change at that one edge.
- R9: With automatic mode off, only software lock writes change the lock bit, and UPDATE pulses and pending flags never do. With automatic mode on, software lock writes are ignored.
- R10: A buffer write in the same cycle as a copy wins over the copy for that channel. The active register takes the old buffered value, the buffer takes the new data, and the pending flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_we | input | NCH | Per-channel buffer write strobe |
| buf_wdata | input | NCH*W | Buffer write data, channel i in bits [i*W +: W] |
| chan_en | input | NCH | Channel enable bits for the all-pending check |
| alock_we | input | 1 | Write strobe for the automatic-mode enable |
| alock_wdata | input | 1 | Value written to the automatic-mode enable |
| lupd_we | input | 1 | Software write strobe for the lock bit |
| lupd_wdata | input | 1 | Value written to the lock bit |
| update | input | 1 | Timer UPDATE pulse |
| cmp_active | output | NCH*W | Active compare values, channel i in bits [i*W +: W] |
| buf_valid | output | NCH | Per-channel pending flags |
| lock_upd | output | 1 | Update-lock bit |

## Verification
The bank is first driven with single-channel writes and manual lock control. These show that a transfer is per channel, that it is blocked by the lock, and that hardware leaves the lock alone when automatic mode is off. Staggered writes to three enabled channels in automatic mode show that the lock holds until the last enabled write lands and that all values then move at one edge. A reduced enable mask, an empty enable mask and a write that collides with a transfer separate the skipping of disabled channels, the immediate release, and the priority of the write over the copy.

// File: rtl/cmpsb_pkg.sv
// Shared types for the compare shadow bank.
// Assumes: nothing beyond IEEE 1800-2017.
package cmpsb_pkg;

    // Action taken on the lock bit in one cycle, listed in priority order
    typedef enum logic [2:0] {
        LK_HOLD   = 3'd0,   // keep value
        LK_ARM    = 3'd1,   // automatic mode just enabled
        LK_RELOCK = 3'd2,   // automatic transfer took place
        LK_FREE   = 3'd3,   // all enabled channels pending
        LK_SW     = 3'd4    // software write, manual mode only
    } lock_act_e;

endpackage

// File: rtl/cmpsb_channel.sv
// One compare channel: a shadow buffer, a pending flag and the active value.
// Assumes: xfer is a single-cycle transfer command that is already qualified
// by the lock bit. A write in the same cycle as a transfer overrides the
// clearing of the pending flag.
module cmpsb_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         xfer,
    output logic [W-1:0] active,
    output logic         pending
);

    logic [W-1:0] shadow_q;
    logic         move;

    // Copy only if a value is waiting
    assign move = xfer && pending;

    // Shadow buffer register: loads on every write
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (wr_en)
            shadow_q <= wr_data;
    end

    // Active compare register: takes the shadow value on a transfer
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= '0;
        else if (move)
            active <= shadow_q;
    end

    // Pending flag: set by a write, cleared by a transfer, write wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (wr_en)
            pending <= 1'b1;
        else if (move)
            pending <= 1'b0;
    end

endmodule

// File: rtl/cmpsb_lock_ctrl.sv
// Update-lock controller: holds the automatic-mode enable and the lock bit,
// and issues the qualified transfer command.
// Assumes: pending flags come from registers. The all-pending check uses the
// current enable mask. The mode in effect before an enable write decides
// the hardware behaviour in that cycle.
module cmpsb_lock_ctrl
    import cmpsb_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] chan_en,
    input  logic [NCH-1:0] pending,
    input  logic           alock_we,
    input  logic           alock_wdata,
    input  logic           lupd_we,
    input  logic           lupd_wdata,
    input  logic           update,
    output logic           xfer,
    output logic           lock_upd,
    output logic           auto_on
);

    logic      all_ready;
    lock_act_e act;

    // Transfer only when an UPDATE arrives and the lock is open
    assign xfer = update && !lock_upd;

    // Disabled channels count as ready
    assign all_ready = &(pending | ~chan_en);

    // Choose this cycle's lock action by priority
    always_comb begin
        act = LK_HOLD;
        if (alock_we && alock_wdata)
            act = LK_ARM;
        else if (auto_on) begin
            if (xfer)
                act = LK_RELOCK;
            else if (lock_upd && all_ready)
                act = LK_FREE;
        end else if (lupd_we)
            act = LK_SW;
    end

    // Automatic-mode enable register
    always_ff @(posedge clk) begin
        if (!rst_n)
            auto_on <= 1'b0;
        else if (alock_we)
            auto_on <= alock_wdata;
    end

    // Lock bit register
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_upd <= 1'b0;
        else begin
            case (act)
                LK_ARM, LK_RELOCK: lock_upd <= 1'b1;
                LK_FREE:           lock_upd <= 1'b0;
                LK_SW:             lock_upd <= lupd_wdata;
                default:           lock_upd <= lock_upd;
            endcase
        end
    end

endmodule

// File: rtl/cmp_shadow_bank.sv
// Top of the compare shadow bank: NCH channels sharing one lock controller.
// Assumes: update is a one-cycle pulse from the timer. Channel data is packed
// with channel i in bits [i*W +: W].
module cmp_shadow_bank #(
    parameter int NCH = 3,
    parameter int W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   buf_we,
    input  logic [NCH*W-1:0] buf_wdata,
    input  logic [NCH-1:0]   chan_en,
    input  logic             alock_we,
    input  logic             alock_wdata,
    input  logic             lupd_we,
    input  logic             lupd_wdata,
    input  logic             update,
    output logic [NCH*W-1:0] cmp_active,
    output logic [NCH-1:0]   buf_valid,
    output logic             lock_upd
);

    logic xfer;
    logic auto_on;

    // Lock controller instance
    cmpsb_lock_ctrl #(.NCH(NCH)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .pending    (buf_valid),
        .alock_we   (alock_we),
        .alock_wdata(alock_wdata),
        .lupd_we    (lupd_we),
        .lupd_wdata (lupd_wdata),
        .update     (update),
        .xfer       (xfer),
        .lock_upd   (lock_upd),
        .auto_on    (auto_on)
    );

    // One channel slice per compare register
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cmpsb_channel #(.W(W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (buf_we[i]),
            .wr_data(buf_wdata[i*W +: W]),
            .xfer   (xfer),
            .active (cmp_active[i*W +: W]),
            .pending(buf_valid[i])
        );
    end

endmodule

// File: rtl/cmp_shadow_bank_chk.sv
// Property checker for the compare shadow bank, bound to the top module.
// Assumes: it sees the top ports and the internal automatic-mode enable.
module cmp_shadow_bank_chk #(
    parameter int NCH = 3,
    parameter int W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   buf_we,
    input logic [NCH-1:0]   chan_en,
    input logic             alock_we,
    input logic             alock_wdata,
    input logic             lupd_we,
    input logic             update,
    input logic [NCH*W-1:0] cmp_active,
    input logic [NCH-1:0]   buf_valid,
    input logic             lock_upd,
    input logic             auto_on
);

    // R2: a written channel shows a pending value next cycle
    a_r2_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (|buf_we) |=> ((buf_valid & $past(buf_we)) == $past(buf_we)));

    // R2, R3: active values move only on an UPDATE
    a_r3_active_needs_update: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> $stable(cmp_active));

    // R4: a locked UPDATE moves nothing
    a_r4_locked_no_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (update && lock_upd) |=> $stable(cmp_active));

    // R5: enabling automatic mode raises the lock
    a_r5_arm_sets_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (alock_we && alock_wdata) |=> lock_upd);

    // R6: automatic mode frees the lock once all enabled channels are pending
    a_r6_free_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_on && lock_upd && !alock_we && (&(buf_valid | ~chan_en)))
        |=> !lock_upd);

    // R8: an automatic transfer relocks
    a_r8_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_on && update && !lock_upd) |=> lock_upd);

    // R9: manual mode without software writes keeps the lock bit
    a_r9_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_on && !alock_we && !lupd_we) |=> $stable(lock_upd));

endmodule

bind cmp_shadow_bank cmp_shadow_bank_chk #(.NCH(NCH), .W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .buf_we     (buf_we),
    .chan_en    (chan_en),
    .alock_we   (alock_we),
    .alock_wdata(alock_wdata),
    .lupd_we    (lupd_we),
    .update     (update),
    .cmp_active (cmp_active),
    .buf_valid  (buf_valid),
    .lock_upd   (lock_upd),
    .auto_on    (auto_on)
);

// File: tb/cmp_shadow_bank_bench.sv
// Scoreboard bench: the driver applies one cycle of stimulus and pushes the
// expected post-edge state; the monitor pops and compares after each edge.
module cmp_shadow_bank_bench;

    localparam int NCH = 3;
    localparam int W   = 16;

    typedef struct {
        string            tag;
        logic [NCH*W-1:0] act;
        logic [NCH-1:0]   val;
        logic             lck;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   buf_we = '0;
    logic [NCH*W-1:0] buf_wdata = '0;
    logic [NCH-1:0]   chan_en = '0;
    logic             alock_we = 1'b0, alock_wdata = 1'b0;
    logic             lupd_we = 1'b0, lupd_wdata = 1'b0;
    logic             update = 1'b0;
    logic [NCH*W-1:0] cmp_active;
    logic [NCH-1:0]   buf_valid;
    logic             lock_upd;

    int n_run = 0, n_fail = 0;
    exp_t q[$];
    bit done = 1'b0;

    // Reference state built from the requirements
    logic [NCH*W-1:0] m_act = '0, m_buf = '0;
    logic [NCH-1:0]   m_val = '0;
    logic             m_lock = 1'b0, m_auto = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cmp_shadow_bank #(.NCH(NCH), .W(W)) u_cmp_shadow_bank (
        .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .chan_en(chan_en), .alock_we(alock_we), .alock_wdata(alock_wdata),
        .lupd_we(lupd_we), .lupd_wdata(lupd_wdata), .update(update),
        .cmp_active(cmp_active), .buf_valid(buf_valid), .lock_upd(lock_upd)
    );

    task automatic check(string tag, exp_t e);
        n_run++;
        if (cmp_active !== e.act || buf_valid !== e.val || lock_upd !== e.lck) begin
            n_fail++;
            $display("FAIL %s: act=%h val=%b lock=%b expected act=%h val=%b lock=%b",
                     tag, cmp_active, buf_valid, lock_upd, e.act, e.val, e.lck);
        end
    endtask

    // Driver: one cycle of stimulus plus the expected result after the edge
    task automatic cyc(string tag, logic [NCH-1:0] we, logic [NCH*W-1:0] wd,
                       logic [NCH-1:0] en, logic awe, logic awd,
                       logic lwe, logic lwd, logic upd);
        logic xf, ready;
        exp_t e;
        @(negedge clk);
        buf_we = we; buf_wdata = wd; chan_en = en;
        alock_we = awe; alock_wdata = awd;
        lupd_we = lwe; lupd_wdata = lwd; update = upd;
        xf    = upd && !m_lock;                 // R3, R4
        ready = &(m_val | ~en);                 // R6, R7
        for (int i = 0; i < NCH; i++) begin
            if (xf && m_val[i]) begin
                m_act[i*W +: W] = m_buf[i*W +: W];
                m_val[i] = 1'b0;
            end
            if (we[i]) begin                    // R2, R10
                m_buf[i*W +: W] = wd[i*W +: W];
                m_val[i] = 1'b1;
            end
        end
        if (awe && awd)            m_lock = 1'b1;          // R5
        else if (m_auto) begin
            if (xf)                m_lock = 1'b1;          // R8
            else if (m_lock && ready) m_lock = 1'b0;       // R6, R7
        end else if (lwe)          m_lock = lwd;           // R9
        if (awe) m_auto = awd;
        e.tag = tag; e.act = m_act; e.val = m_val; e.lck = m_lock;
        q.push_back(e);
    endtask

    // Monitor: compare shortly after each rising edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, e);
        end
    end

    function automatic logic [NCH*W-1:0] pk(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        return {c, b, a};
    endfunction

    // Watchdog
    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        #2;
        r.tag = "R1 reset"; r.act = '0; r.val = '0; r.lck = 1'b0;
        check(r.tag, r);
        @(negedge clk); rst_n = 1'b1;

        // Manual mode
        cyc("R2 write ch0",        3'b001, pk(16'h1111,0,0), 3'b111, 0,0, 0,0, 0);
        cyc("R3 unlocked copy",    3'b000, '0,               3'b111, 0,0, 0,0, 1);
        cyc("R9 sw lock set",      3'b000, '0,               3'b111, 0,0, 1,1, 0);
        cyc("R2 write ch1",        3'b010, pk(0,16'h2222,0), 3'b111, 0,0, 0,0, 0);
        cyc("R4 locked update",    3'b000, '0,               3'b111, 0,0, 0,0, 1);
        cyc("R9 lock holds",       3'b000, '0,               3'b111, 0,0, 0,0, 1);
        cyc("R9 sw lock clear",    3'b000, '0,               3'b111, 0,0, 1,0, 0);
        cyc("R3 copy ch1 only",    3'b000, '0,               3'b111, 0,0, 0,0, 1);
        cyc("R9 no hw relock",     3'b000, '0,               3'b111, 0,0, 0,0, 0);

        // Automatic mode, all three enabled
        cyc("R5 arm",              3'b000, '0,               3'b111, 1,1, 0,0, 0);
        cyc("R6 idle locked",      3'b000, '0,               3'b111, 0,0, 0,0, 0);
        cyc("R6 write ch0",        3'b001, pk(16'hA0A0,0,0), 3'b111, 0,0, 0,0, 0);
        cyc("R6 write ch1",        3'b010, pk(0,16'hB1B1,0), 3'b111, 0,0, 0,0, 0);
        cyc("R4 update partial",   3'b000, '0,               3'b111, 0,0, 0,0, 1);
        cyc("R6 write ch2",        3'b100, pk(0,0,16'hC2C2), 3'b111, 0,0, 0,0, 0);
        cyc("R6 lock frees",       3'b000, '0,               3'b111, 0,0, 0,0, 0);
        cyc("R9 sw write ignored", 3'b000, '0,               3'b111, 0,0, 1,1, 0);
        cyc("R8 joint copy",       3'b000, '0,               3'b111, 0,0, 0,0, 1);
        cyc("R9 sw clear ignored", 3'b000, '0,               3'b111, 0,0, 1,0, 0);

        // Reduced enable mask
        cyc("R6 ch0 only write",   3'b001, pk(16'h0D0D,0,0), 3'b001, 0,0, 0,0, 0);
        cyc("R6 disabled skipped", 3'b000, '0,               3'b001, 0,0, 0,0, 0);
        cyc("R10 write on copy",   3'b001, pk(16'h0E0E,0,0), 3'b001, 0,0, 0,0, 1);
        cyc("R10 pending kept",    3'b000, '0,               3'b001, 0,0, 0,0, 0);
        cyc("R8 second copy",      3'b000, '0,               3'b001, 0,0, 0,0, 1);

        // Empty enable mask
        cyc("R9 disarm",           3'b000, '0,               3'b000, 1,0, 0,0, 0);
        cyc("R9 sw clear manual",  3'b000, '0,               3'b000, 0,0, 1,0, 0);
        cyc("R7 arm empty mask",   3'b000, '0,               3'b000, 1,1, 0,0, 0);
        cyc("R7 immediate free",   3'b000, '0,               3'b000, 0,0, 0,0, 0);
        cyc("R7 stays free",       3'b000, '0,               3'b000, 0,0, 0,0, 0);

        @(negedge clk);
        buf_we = '0; update = 1'b0; lupd_we = 1'b0; alock_we = 1'b0;
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule